// File: doc/BRIEF.md
# Reference-Synchronised Oscillator Trim Controller

This block compares a free-running internal oscillator with a slow periodic reference sync pulse and corrects the oscillator through a trim code. Every sync pulse reloads a measurement counter with a programmed value. The counter then counts oscillator cycles down to zero, turns around, and counts up until it reaches 128 times a programmed limit. When the next sync pulse arrives, the counter value and its direction at that moment show how far the oscillator is off and in which direction.

At each sync pulse the block stores the counter value and the direction. It grades the error as fine, warning or error, and sets sticky status flags. When automatic trimming is enabled, it moves the trim code by one or two steps toward the correct frequency. The status flags are cleared by write-one-to-clear. An interrupt line reports any flag whose enable is set. Software can also overwrite the trim code at any time. The reference input is treated as asynchronous. It is synchronised and edge-detected, so each pulse is acted on exactly once. The limit must be at least 1.

Top module: `osc_trim_ctrl`

## Requirements
- R1: On each detected sync pulse the counter loads `cfg_reload_i` with direction down, then decrements by one on every clock.
- R2: A down-counting counter at zero switches to up-counting (next value 1). Up-counting stops at 128 × `cfg_limit_i` and the counter holds that value until the next pulse.
- R3: At each pulse the counter value in use at that moment is stored in `cap_value_o`, and its direction in `cap_dir_o` (0 = down, 1 = up).
- R4: A captured value below the limit sets flag bit 0 (fine).
- R5: A captured value from the limit up to 3 × limit (inclusive) sets flag bit 1 (warning). A value above 3 × limit sets flag bit 2 (error).
- R6: With `cfg_auto_i` = 1, a down-direction capture raises the trim code and an up-direction capture lowers it. The step is 1 for fine, 2 for warning and 0 for error.
- R7: With `cfg_auto_i` = 0, pulses update the status only. The trim code changes only through `trim_wr_i`, which loads `trim_wdata_i`. The trim code resets to 64.
- R8: Automatic trim saturates at 0 and at 2^TRIM_W − 1 and never wraps.
- R9: Reaching 128 × limit while counting up without a pulse sets flag bit 3 (reference missed).
- R10: Flags are sticky. A 1 in a bit of `stat_clr_i` clears that flag and leaves the other flags unchanged.
- R11: `irq_o` is high exactly when some flag is set whose bit in `cfg_irq_en_i` is also set.
- R12: A sync pulse held high for many cycles acts only once, on its rising edge. The capture happens on the third clock edge after the input rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ref_pulse_i | input | 1 | Asynchronous reference sync pulse |
| cfg_reload_i | input | CNT_W | Counter reload value |
| cfg_limit_i | input | LIM_W | Grading limit |
| cfg_auto_i | input | 1 | Automatic trim enable |
| cfg_irq_en_i | input | 4 | Interrupt enable per flag |
| trim_wr_i | input | 1 | Software trim write strobe |
| trim_wdata_i | input | TRIM_W | Software trim value |
| stat_clr_i | input | 4 | Write-one-to-clear for flags |
| stat_flags_o | output | 4 | Sticky flags {missed, error, warning, fine} |
| cap_value_o | output | CNT_W | Captured counter value |
| cap_dir_o | output | 1 | Captured direction, 1 = up |
| trim_o | output | TRIM_W | Trim code to the oscillator |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench captures counter values exactly at the grading edges: 0, the limit minus one, the limit, 3 × limit and 3 × limit + 1, in both directions. A design with an off-by-one compare would set the wrong flag and take the wrong trim step. It loads the trim code with its top and bottom values to test saturation; a wrapping adder would jump to the far end of the range. It lets the reference go missing so the counter must stop at 128 × limit. One long pulse tests that a level-sensitive reload, which would shift the next capture, is not present. It also clears flags bit by bit to find a clear that wipes the whole register.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } cnt_dir_e;

    localparam int FLAG_N   = 4;
    localparam int FLG_FINE = 0;
    localparam int FLG_WARN = 1;
    localparam int FLG_ERR  = 2;
    localparam int FLG_MISS = 3;

    typedef struct packed {
        logic       fine;
        logic       warn;
        logic       err;
        logic [1:0] step;
    } grade_t;

    // Grade a captured count against the limit; step is the trim magnitude.
    function automatic grade_t grade(input int unsigned cnt, input int unsigned lim);
        grade_t g;
        g = '0;
        if (cnt < lim) begin
            g.fine = 1'b1;
            g.step = 2'd1;
        end else if (cnt <= 3 * lim) begin
            g.warn = 1'b1;
            g.step = 2'd2;
        end else begin
            g.err = 1'b1;
        end
        return g;
    endfunction

endpackage

// File: rtl/osc_trim_sync.sv
module osc_trim_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/osc_trim_counter.sv
module osc_trim_counter
    import osc_trim_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             evt_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic [CNT_W-1:0] top_i,
    output logic [CNT_W-1:0] cnt_o,
    output cnt_dir_e         dir_o,
    output logic             miss_o
);
    logic [CNT_W-1:0] cnt_q;
    cnt_dir_e         dir_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
            dir_q <= DIR_UP;
        end else if (evt_i) begin
            cnt_q <= reload_i;
            dir_q <= DIR_DOWN;
        end else if (dir_q == DIR_DOWN) begin
            if (cnt_q == '0) begin
                dir_q <= DIR_UP;
                cnt_q <= CNT_W'(1);
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (cnt_q < top_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // One-shot: fires on the step that lands on the ceiling.
    assign miss_o = !evt_i && (dir_q == DIR_UP) && (cnt_q < top_i)
                    && ((cnt_q + 1'b1) == top_i);
    assign cnt_o  = cnt_q;
    assign dir_o  = dir_q;
endmodule

// File: rtl/osc_trim_adjust.sv
module osc_trim_adjust #(
    parameter int TRIM_W   = 7,
    parameter int TRIM_RST = 64
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_i,
    input  logic [TRIM_W-1:0] wdata_i,
    input  logic              apply_i,
    input  logic              raise_i,
    input  logic [1:0]        step_i,
    output logic [TRIM_W-1:0] trim_o
);
    localparam logic [TRIM_W:0] TOP = {1'b0, {TRIM_W{1'b1}}};

    logic [TRIM_W-1:0] trim_q, trim_nxt;
    logic [TRIM_W:0]   ext, stepx, sum;

    always_comb begin
        ext   = {1'b0, trim_q};
        stepx = (TRIM_W+1)'(step_i);
        sum   = ext + stepx;
        if (raise_i)
            trim_nxt = (sum > TOP) ? TOP[TRIM_W-1:0] : sum[TRIM_W-1:0];
        else
            trim_nxt = (ext < stepx) ? '0 : trim_q - stepx[TRIM_W-1:0];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)        trim_q <= TRIM_W'(TRIM_RST);
        else if (wr_i)    trim_q <= wdata_i;
        else if (apply_i) trim_q <= trim_nxt;
    end

    assign trim_o = trim_q;
endmodule

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl
    import osc_trim_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int LIM_W    = 8,
    parameter int TRIM_W   = 7,
    parameter int TRIM_RST = 64,
    parameter int SYNC_N   = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              ref_pulse_i,
    input  logic [CNT_W-1:0]  cfg_reload_i,
    input  logic [LIM_W-1:0]  cfg_limit_i,
    input  logic              cfg_auto_i,
    input  logic [FLAG_N-1:0] cfg_irq_en_i,
    input  logic              trim_wr_i,
    input  logic [TRIM_W-1:0] trim_wdata_i,
    input  logic [FLAG_N-1:0] stat_clr_i,
    output logic [FLAG_N-1:0] stat_flags_o,
    output logic [CNT_W-1:0]  cap_value_o,
    output logic              cap_dir_o,
    output logic [TRIM_W-1:0] trim_o,
    output logic              irq_o
);
    localparam int TOP_W = LIM_W + 7;

    logic              pulse_evt, miss_evt;
    logic [CNT_W-1:0]  cnt_q, count_top;
    cnt_dir_e          dir_q;
    grade_t            g;
    logic [FLAG_N-1:0] flag_q, flag_set;

    assign count_top = CNT_W'({cfg_limit_i, 7'b0});

    osc_trim_sync #(.STAGES(SYNC_N)) u_sync (
        .clk_i(clk_i), .rst_i(rst_i), .async_i(ref_pulse_i), .rise_o(pulse_evt)
    );

    osc_trim_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i(clk_i), .rst_i(rst_i), .evt_i(pulse_evt),
        .reload_i(cfg_reload_i), .top_i(count_top),
        .cnt_o(cnt_q), .dir_o(dir_q), .miss_o(miss_evt)
    );

    assign g = grade(32'(cnt_q), 32'(cfg_limit_i));

    osc_trim_adjust #(.TRIM_W(TRIM_W), .TRIM_RST(TRIM_RST)) u_adj (
        .clk_i(clk_i), .rst_i(rst_i),
        .wr_i(trim_wr_i), .wdata_i(trim_wdata_i),
        .apply_i(pulse_evt && cfg_auto_i && (g.step != 2'd0)),
        .raise_i(dir_q == DIR_DOWN), .step_i(g.step),
        .trim_o(trim_o)
    );

    always_comb begin
        flag_set           = '0;
        flag_set[FLG_FINE] = pulse_evt & g.fine;
        flag_set[FLG_WARN] = pulse_evt & g.warn;
        flag_set[FLG_ERR]  = pulse_evt & g.err;
        flag_set[FLG_MISS] = miss_evt;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            flag_q      <= '0;
            cap_value_o <= '0;
            cap_dir_o   <= 1'b0;
        end else begin
            flag_q <= (flag_q & ~stat_clr_i) | flag_set;
            if (pulse_evt) begin
                cap_value_o <= cnt_q;
                cap_dir_o   <= dir_q;
            end
        end
    end

    assign stat_flags_o = flag_q;
    assign irq_o        = |(flag_q & cfg_irq_en_i);

    if (TOP_W > CNT_W) begin : g_width_bad
        initial $error("CNT_W must hold 128 x limit");
    end
endmodule

// File: rtl/osc_trim_ctrl_chk.sv
module osc_trim_ctrl_chk #(
    parameter int CNT_W  = 16,
    parameter int LIM_W  = 8,
    parameter int TRIM_W = 7
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              evt_i,
    input logic [CNT_W-1:0]  cnt_i,
    input logic              dir_i,
    input logic [CNT_W-1:0]  reload_i,
    input logic [LIM_W-1:0]  lim_i,
    input logic [CNT_W-1:0]  cap_value_i,
    input logic              cap_dir_i,
    input logic [TRIM_W-1:0] trim_i,
    input logic              trim_wr_i,
    input logic [3:0]        flags_i,
    input logic [3:0]        clr_i
);
    localparam logic [TRIM_W-1:0] TMAX = {TRIM_W{1'b1}};

    p_reload_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        evt_i |=> (cnt_i == $past(reload_i)) && (dir_i == 1'b0));

    p_hold_top_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!evt_i && dir_i && (32'(cnt_i) >= 128 * 32'(lim_i))) |=> (cnt_i == $past(cnt_i)));

    p_capture_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        evt_i |=> (cap_value_i == $past(cnt_i)) && (cap_dir_i == $past(dir_i)));

    p_err_keeps_trim_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (evt_i && !trim_wr_i && (32'(cnt_i) > 3 * 32'(lim_i))) |=> $stable(trim_i));

    p_trim_idle_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!evt_i && !trim_wr_i) |=> $stable(trim_i));

    p_sat_top_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (evt_i && !trim_wr_i && !dir_i && trim_i == TMAX) |=> (trim_i == TMAX));

    p_sat_bottom_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (evt_i && !trim_wr_i && dir_i && trim_i == '0) |=> (trim_i == '0));

    p_sticky_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((flags_i & $past(flags_i & ~clr_i)) == $past(flags_i & ~clr_i)));

    p_once_r12: assert property (@(posedge clk_i) disable iff (rst_i)
        evt_i |=> !evt_i);
endmodule

bind osc_trim_ctrl osc_trim_ctrl_chk #(
    .CNT_W(CNT_W), .LIM_W(LIM_W), .TRIM_W(TRIM_W)
) u_chk (
    .clk_i(clk_i), .rst_i(rst_i), .evt_i(pulse_evt),
    .cnt_i(cnt_q), .dir_i(dir_q), .reload_i(cfg_reload_i),
    .lim_i(cfg_limit_i), .cap_value_i(cap_value_o), .cap_dir_i(cap_dir_o),
    .trim_i(trim_o), .trim_wr_i(trim_wr_i),
    .flags_i(stat_flags_o), .clr_i(stat_clr_i)
);

// File: tb/osc_trim_ctrl_tb.sv
`timescale 1ns/1ps
module osc_trim_ctrl_tb;
    localparam int CNT_W = 16, LIM_W = 8, TRIM_W = 7;
    localparam int NV = 8;
    // gap = rise-to-rise cycles before this pulse; hi = pulse width
    localparam int V_GAP [NV] = '{101, 99, 104, 105, 89, 88, 121, 100};
    localparam int V_HI  [NV] = '{6, 6, 6, 6, 6, 6, 30, 6};
    localparam int V_CAP [NV] = '{0, 2, 3, 4, 12, 13, 20, 1};
    localparam int V_DIR [NV] = '{0, 0, 1, 1, 0, 0, 1, 0};
    localparam int V_FLG [NV] = '{1, 1, 1, 2, 2, 4, 4, 1};
    localparam int V_TRM [NV] = '{65, 66, 65, 63, 65, 65, 65, 66};

    logic clk = 1'b0, rst = 1'b1, ref_p = 1'b0, auto_en = 1'b0;
    logic trim_wr = 1'b0, cap_dir, irq;
    logic [CNT_W-1:0]  reload = 16'd100, cap_value;
    logic [LIM_W-1:0]  limit = 8'd4;
    logic [3:0]        irq_en = 4'h0, clr = 4'h0, flags;
    logic [TRIM_W-1:0] trim_wdata = '0, trim;

    int n_run = 0, n_fail = 0, elapsed = 0, cycles = 0;

    always #2.5 clk = ~clk;

    osc_trim_ctrl u_dut (
        .clk_i(clk), .rst_i(rst), .ref_pulse_i(ref_p),
        .cfg_reload_i(reload), .cfg_limit_i(limit), .cfg_auto_i(auto_en),
        .cfg_irq_en_i(irq_en), .trim_wr_i(trim_wr), .trim_wdata_i(trim_wdata),
        .stat_clr_i(clr), .stat_flags_o(flags), .cap_value_o(cap_value),
        .cap_dir_o(cap_dir), .trim_o(trim), .irq_o(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        elapsed += n;
    endtask

    task automatic fire(input int gap);
        idle(gap - elapsed);
        ref_p = 1'b1;
        repeat (4) @(negedge clk);
        elapsed = 4;
    endtask

    task automatic tidy(input int hi, input logic [3:0] mask);
        clr = mask;
        @(negedge clk);
        clr = 4'h0;
        repeat (hi - 5) @(negedge clk);
        ref_p = 1'b0;
        elapsed = hi;
    endtask

    task automatic write_trim(input int v);
        trim_wr = 1'b1;
        trim_wdata = TRIM_W'(v);
        @(negedge clk);
        trim_wr = 1'b0;
        elapsed += 1;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 200000);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R7 reset trim", int'(trim), 64);
        check("R10 reset flags", int'(flags), 0);
        check("R11 reset irq", int'(irq), 0);

        // Baseline pulse with auto trim off: trim untouched.
        elapsed = 0;
        fire(0);
        check("R7 auto off keeps trim", int'(trim), 64);
        tidy(6, 4'hF);
        auto_en = 1'b1;
        idle(1);

        // Table: R1..R6, R12 (vector 6 holds the pulse 30 cycles).
        for (int i = 0; i < NV; i++) begin
            fire(V_GAP[i]);
            check($sformatf("R3 cap value v%0d", i), int'(cap_value), V_CAP[i]);
            check($sformatf("R3 cap dir v%0d", i), int'(cap_dir), V_DIR[i]);
            check($sformatf("R4 R5 flags v%0d", i), int'(flags), V_FLG[i]);
            check($sformatf("R6 R1 R12 trim v%0d", i), int'(trim), V_TRM[i]);
            tidy(V_HI[i], 4'hF);
        end

        // R9 / R2: reference goes missing, counter stops at 128 x limit.
        auto_en = 1'b0;
        idle(580 - elapsed);
        check("R9 no miss before ceiling", int'(flags), 0);
        idle(70);
        check("R9 miss flag", int'(flags), 8);
        check("R11 irq masked", int'(irq), 0);
        irq_en = 4'h8;
        #1;
        check("R11 irq on miss", int'(irq), 1);
        fire(700);
        check("R2 held at ceiling", int'(cap_value), 512);
        check("R2 dir up at ceiling", int'(cap_dir), 1);
        check("R5 error and miss sticky", int'(flags), 12);
        check("R7 no trim when auto off", int'(trim), 66);
        tidy(6, 4'h4);
        check("R10 partial clear", int'(flags), 8);
        check("R11 irq still set", int'(irq), 1);
        clr = 4'h8;
        @(negedge clk);
        clr = 4'h0;
        elapsed += 1;
        check("R10 clear miss", int'(flags), 0);
        check("R11 irq dropped", int'(irq), 0);

        // R8: saturation at both ends.
        auto_en = 1'b1;
        irq_en = 4'h1;
        write_trim(127);
        fire(101);
        check("R8 top saturation", int'(trim), 127);
        check("R11 irq on fine", int'(irq), 1);
        tidy(6, 4'hF);
        write_trim(1);
        fire(105);
        check("R8 bottom saturation", int'(trim), 0);
        tidy(6, 4'hF);
        write_trim(126);
        fire(89);
        check("R8 clamp step two", int'(trim), 127);
        check("R5 warn at 3x limit", int'(flags), 2);
        tidy(6, 4'hF);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule